// File: doc/BRIEF.md
# Short-Pulse Asynchronous Input Catcher

This block brings one asynchronous input into the clock domain of `clk_i`. The input may carry glitch-like pulses much narrower than a clock period, or levels held for many periods. An input flop is clocked by the rising edge of the input itself, so any pulse is held until the clock domain has seen it. Its output passes through a chain of `STAGES` clocked flops. The first flop in that chain may go metastable. The flops after it give it at least one full period to settle before the value is used.

The last flop of the chain is the synchronized level `level_o`. It feeds back and clears the input flop as soon as it goes high. This makes the catcher ready for the next pulse once the current event has drained out of the chain. `strobe_o` marks the first cycle of each event for logic that wants one pulse per input event. All pulses that fall inside one clock period are merged into a single event. The raw input drives only the catch flop and no other logic.

Top module: `apulse_catch`

## Requirements
- R1: A single input pulse narrower than one clock period, with both edges between two rising clock edges, produces exactly one event (one strobe cycle).
- R2: An input held high for many clock periods produces exactly one event, however long it stays high.
- R3: If the input rises between clock edges E0 and E1, `strobe_o` and `level_o` go high after edge E(STAGES). The latency is STAGES clock edges after the edge that precedes the pulse, and never fewer than two.
- R4: Several pulses that all fall within one clock period are merged into one event.
- R5: For every event, `level_o` stays high for exactly STAGES consecutive cycles and then returns low.
- R6: `strobe_o` is high for exactly one cycle per event. That cycle is the first cycle in which `level_o` is high, and `strobe_o` is never high while `level_o` is low.
- R7: While `rst_i` is high, the catch flop is cleared. After the first clock edge with `rst_i` high, `level_o` and `strobe_o` are low. A pulse that arrives and ends during reset produces no event after reset is released.
- R8: Pulses whose rising edges are at least 2*STAGES+2 clock periods apart each produce their own event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination clock; all synchronizer flops use its rising edge |
| rst_i | input | 1 | Synchronous reset, active high; also holds the catch flop clear |
| pulse_i | input | 1 | Asynchronous input; its rising edge is what gets caught |
| level_o | output | 1 | Synchronized event level, high STAGES cycles per event |
| strobe_o | output | 1 | One-cycle marker on the first cycle of each event |

## Verification
The assertions assume three things about the input. Input rising edges are spaced far enough apart that none lands while the feedback clear is active, since an edge in that window is not captured. Input rising edges never coincide with a clock edge. Reset is held for at least one clock edge before it is released. The bench places every pulse edge a few nanoseconds after a rising clock edge. It spaces events by at least 3*STAGES+4 periods, except in the directed spacing case, which uses exactly the minimum. Random cases choose between single narrow pulses, bursts inside one period and long held levels.

// File: rtl/apc_pkg.sv
`timescale 1ns/1ps
package apc_pkg;
  // Fewest flops that still leave one full period for the first to settle.
  localparam int unsigned APC_MIN_STAGES = 2;

  function automatic int unsigned apc_depth(input int unsigned req);
    return (req < APC_MIN_STAGES) ? APC_MIN_STAGES : req;
  endfunction
endpackage

// File: rtl/apc_capture.sv
`timescale 1ns/1ps
// Edge catch flop: set by the raw input edge, cleared asynchronously.
module apc_capture (
  input  logic trig_i,
  input  logic clr_i,
  output logic caught_o
);
  always_ff @(posedge trig_i or posedge clr_i) begin
    if (clr_i) caught_o <= 1'b0;
    else       caught_o <= 1'b1;
  end
endmodule

// File: rtl/apc_sync_chain.sv
`timescale 1ns/1ps
// Shift chain of clocked flops; stage 0 samples the asynchronous value.
module apc_sync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stage;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      logic src;
      if (g == 0) begin : g_head
        assign src = d_i;
      end else begin : g_tail
        assign src = stage[g-1];
      end
      always_ff @(posedge clk_i) begin
        if (rst_i) stage[g] <= 1'b0;
        else       stage[g] <= src;
      end
    end
  endgenerate

  assign q_o = stage[DEPTH-1];
endmodule

// File: rtl/apc_edge_mark.sv
`timescale 1ns/1ps
// Marks the first cycle of a high run on a synchronous level.
module apc_edge_mark (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic mark_o
);
  logic lvl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) lvl_q <= 1'b0;
    else       lvl_q <= lvl_i;
  end

  assign mark_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/apulse_catch.sv
`timescale 1ns/1ps
module apulse_catch #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pulse_i,
  output logic level_o,
  output logic strobe_o
);
  localparam int unsigned DEPTH = apc_pkg::apc_depth(STAGES);

  logic caught;
  logic sync_lvl;
  logic clr_catch;

  // Reset or a visible event empties the catch flop.
  assign clr_catch = rst_i | sync_lvl;

  apc_capture u_capture (
    .trig_i   (pulse_i),
    .clr_i    (clr_catch),
    .caught_o (caught)
  );

  apc_sync_chain #(.DEPTH(DEPTH)) u_chain (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (caught),
    .q_o   (sync_lvl)
  );

  apc_edge_mark u_mark (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (sync_lvl),
    .mark_o (strobe_o)
  );

  assign level_o = sync_lvl;
endmodule

// File: rtl/apc_checks.sv
`timescale 1ns/1ps
module apc_checks #(
  parameter int unsigned STAGES = 2
) (
  input logic clk_i,
  input logic rst_i,
  input logic level_i,
  input logic strobe_i,
  input logic caught_i
);
  localparam int unsigned CW = $clog2(STAGES + 2) + 1;

  logic [CW-1:0] hi_run;

  always_ff @(posedge clk_i) begin
    if (rst_i)        hi_run <= '0;
    else if (level_i) hi_run <= hi_run + 1'b1;
    else              hi_run <= '0;
  end

  // R7
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!level_i && !strobe_i));

  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |=> !strobe_i);

  // R6
  strobe_on_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |-> level_i);

  // R6
  rise_marked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(level_i) |-> strobe_i);

  // R5
  run_length_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(level_i) |-> (hi_run == CW'(STAGES)));

  // R5
  run_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    level_i |-> (hi_run < CW'(STAGES)));

  // R8
  catch_freed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_i && $past(level_i)) |-> !caught_i);
endmodule

bind apulse_catch apc_checks #(.STAGES(DEPTH)) u_checks (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .level_i  (level_o),
  .strobe_i (strobe_o),
  .caught_i (caught)
);

// File: tb/apulse_catch_bench.sv
`timescale 1ns/1ps
module apulse_catch_bench;
  localparam int unsigned STG = 3;
  localparam int unsigned GAP = 3 * STG + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic level, strobe;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_strobe = 0, n_hi = 0, strobe_cyc = 0, launch_cyc = 0;
  int r6_viol = 0;
  logic strobe_prev = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  apulse_catch #(.STAGES(STG)) u_apulse_catch (
    .clk_i(clk), .rst_i(rst), .pulse_i(pulse_in),
    .level_o(level), .strobe_o(strobe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (strobe) begin n_strobe++; strobe_cyc = cyc; end
      if (level) n_hi++;
      if ((strobe && strobe_prev) || (strobe && !level)) r6_viol++;
    end
    strobe_prev = strobe;
  end

  function automatic int exp_latency();
    return STG;
  endfunction

  function automatic int exp_hi_run(input int events);
    return events * STG;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic narrow(input int w);
    pulse_in = 1'b1; #(w); pulse_in = 1'b0;
  endtask

  // kind 0: narrow single, 1: burst in one period, 2: long level
  task automatic run_event(input int kind);
    int s0, h0;
    string tag;
    s0 = n_strobe; h0 = n_hi;
    @(posedge clk); #(2 + $urandom % 3);
    launch_cyc = cyc;
    if (kind == 0) begin
      narrow(1 + $urandom % 4); tag = "R1";
    end else if (kind == 1) begin
      narrow(2); #2; narrow(1 + $urandom % 2); #2; narrow(1); tag = "R4";
    end else begin
      pulse_in = 1'b1;
      repeat (2 + $urandom % 12) @(posedge clk);
      #3 pulse_in = 1'b0; tag = "R2";
    end
    repeat (GAP) @(posedge clk);
    @(negedge clk);
    chk(n_strobe - s0 == 1, tag, n_strobe - s0, 1);
    chk(n_hi - h0 == exp_hi_run(1), "R5", n_hi - h0, exp_hi_run(1));
    chk(strobe_cyc - launch_cyc == exp_latency(), "R3",
        strobe_cyc - launch_cyc, exp_latency());
  endtask

  initial begin
    int s0, h0, c1, c2;
    void'($urandom(32'd9127));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(level == 1'b0 && strobe == 1'b0, "R7 reset state", {level, strobe}, 0);
    #2 rst = 1'b0;

    // Directed: each kind once, then random mix
    run_event(0);
    run_event(1);
    run_event(2);
    for (int i = 0; i < 30; i++) run_event(int'($urandom % 3));

    // R3: latency never below two edges
    chk(exp_latency() >= 2 && strobe_cyc - launch_cyc >= 2, "R3 min",
        strobe_cyc - launch_cyc, exp_latency());

    // R8: two pulses at the minimum spacing
    s0 = n_strobe;
    @(posedge clk); #4; c1 = cyc; narrow(3);
    repeat (2 * STG + 1) @(posedge clk);
    @(posedge clk); #4; c2 = cyc; narrow(2);
    repeat (GAP) @(posedge clk);
    @(negedge clk);
    chk(n_strobe - s0 == 2, "R8 events", n_strobe - s0, 2);
    chk(strobe_cyc - c2 == exp_latency(), "R8 second latency", strobe_cyc - c2, exp_latency());
    chk(c2 - c1 == 2 * STG + 2, "R8 spacing", c2 - c1, 2 * STG + 2);

    // R7: pulse entirely inside reset gives nothing afterwards
    s0 = n_strobe; h0 = n_hi;
    @(posedge clk); #2 rst = 1'b1;
    @(posedge clk); #4 narrow(3);
    @(negedge clk);
    chk(level == 1'b0 && strobe == 1'b0, "R7 during reset", {level, strobe}, 0);
    @(posedge clk); #2 rst = 1'b0;
    repeat (GAP) @(posedge clk);
    @(negedge clk);
    chk(n_strobe - s0 == 0, "R7 no event", n_strobe - s0, 0);
    chk(n_hi - h0 == 0 && level == 1'b0, "R7 level low", n_hi - h0, 0);

    // Catcher still works after reset
    run_event(0);

    chk(r6_viol == 0, "R6 strobe shape", r6_viol, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule